// File: doc/BRIEF.md
# Banked Host Register Interface

This block is the host-facing register file of a network controller. It has sixteen byte offsets, and three register banks share them. Offset 0 appears in every bank. It is a command register: bits 7:6 choose which bank the other offsets reach, and bits 5:0 carry a command code. The block produces a one-cycle command strobe for the controller's engines. It also drives the configuration values that software programs: receive base and stop pointers, buffer limit pages, interrupt mask and station address. It keeps the interrupt status bits, which are set by events and cleared when the host writes 1s to them.

Bank 0 also holds a chip identification register. Software uses it to confirm the chip is present. It carries a fixed signature and a two-bit counter that steps on every read. Bank 0 also gives indirect access to an external packet buffer RAM. Software loads a host address pointer, and each access to the data port moves one 16-bit word and advances the pointer by 2.

The host side has a 16-bit write data bus. The word registers take all 16 bits. The byte registers take bits 7:0 and read back zero-extended. Read data is combinational from the current state. Any side effect of a read, such as a counter step or a pointer advance, takes place at the clock edge that ends the access.

Top module: `bank_reg_if`

## Requirements
- R1: A write to offset 0 in any bank loads bits 7:6 of the data into the bank select (0, 1, 2 or 3). A read of offset 0 returns the bank select in bits 7:6 and zero elsewhere.
- R2: A write to offset 0 whose bits 5:0 hold one of the codes 0x03, 0x04, 0x07, 0x08, 0x0A, 0x0B, 0x0E, 0x18, 0x1C or 0x1E raises `cmd_stb` for exactly the next cycle, with `cmd_code` equal to that code. Any other code, including 0x00, raises no strobe.
- R3: Code 0x0E (full reset) also forces the bank select to 0 and clears the four status event bits and the interrupt mask. This holds whatever bank bits were written with it and whatever events arrive in the same cycle.
- R4: In bank 0, a read of offset 2 returns {cnt, 6'b100100}, which is 0x24 under mask 0x2C. Each such read advances the two-bit counter `cnt` by 1, wrapping from 3 to 0.
- R5: In bank 0, offset 1 is the status register. Bit 0 is receive-stop, bit 1 is receive, bit 2 is transmit and bit 3 is execution event. Each bit is set by its event input. A write clears each bit whose data bit is 1, and an event in the same cycle wins over the clear. Bits 5:4 show the `exec_state` input, and bits 7:6 read 0.
- R6: In bank 0, offset 3 holds the four-bit interrupt mask in bits 3:0 (same bit order as the status events). Bits 7:4 read 0.
- R7: In bank 0, offsets 0x4, 0x6 and 0xC hold the 16-bit receive base, receive stop pointer and host address pointer. A write stores all 16 bits, and a read returns them.
- R8: In bank 0, a write to offset 0xE stores the data in the buffer word at the host address. A read of 0xE returns the buffer word at the host address. Either access then adds 2 to the host address, wrapping at 16 bits.
- R9: In bank 1, offsets 0x8, 0x9, 0xA and 0xB hold the receive lower, receive upper, transmit lower and transmit upper limit pages, one byte each.
- R10: In bank 2, offsets 0x4 to 0x9 hold the six station address bytes. Offset 0x4+i drives `station_addr[8i+7:8i]`.
- R11: Every offset not listed above reads 0x0000, and writes to it change nothing. Bank 3 has only offset 0. A read of any offset other than 0x2 or 0xE has no side effect.
- R12: After reset, the bank select, every register, the ID counter, the host address and `cmd_stb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| host_rdata | output | 16 | Read data for the addressed offset |
| buf_addr | output | 16 | Buffer RAM byte address (host pointer) |
| buf_we | output | 1 | Buffer word write strobe |
| buf_re | output | 1 | Buffer word read strobe |
| buf_wdata | output | 16 | Buffer write word |
| buf_rdata | input | 16 | Buffer read word at `buf_addr` |
| evt_rx_stop | input | 1 | Sets status bit 0 |
| evt_rx | input | 1 | Sets status bit 1 |
| evt_tx | input | 1 | Sets status bit 2 |
| evt_exec | input | 1 | Sets status bit 3 |
| exec_state | input | 2 | Execution state shown in status bits 5:4 |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 6 | Code of the last strobed command |
| bank_sel | output | 2 | Active bank |
| int_mask | output | 4 | Interrupt mask |
| rx_base | output | 16 | Receive base address |
| rx_stop | output | 16 | Receive stop pointer |
| rx_lo_page | output | 8 | Receive lower limit page |
| rx_hi_page | output | 8 | Receive upper limit page |
| tx_lo_page | output | 8 | Transmit lower limit page |
| tx_hi_page | output | 8 | Transmit upper limit page |
| station_addr | output | 48 | Station address, byte i in bits 8i+7:8i |

## Verification
The assertions check these rules on every cycle: the strobe follows a listed command code and is absent after a plain bank select; a full reset returns the bank, mask and status to zero; the identification counter steps by one and the signature bits hold on every read; the host pointer advances by two on each data port read; station address byte 0 follows its write; bank 3 reads zero. Only the bench scenarios show the rest. These are the set-over-clear race on the status bits, counter wrap over many reads, and that data written through the port comes back in order after the pointer is reloaded. They also show that writes to unused offsets leave every configuration output unchanged, which needs the whole register state to be modelled.

// File: rtl/bank_reg_if.sv
module bank_reg_if (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic [15:0] buf_addr,
  output logic        buf_we,
  output logic        buf_re,
  output logic [15:0] buf_wdata,
  input  logic [15:0] buf_rdata,
  input  logic        evt_rx_stop,
  input  logic        evt_rx,
  input  logic        evt_tx,
  input  logic        evt_exec,
  input  logic [1:0]  exec_state,
  output logic        cmd_stb,
  output logic [5:0]  cmd_code,
  output logic [1:0]  bank_sel,
  output logic [3:0]  int_mask,
  output logic [15:0] rx_base,
  output logic [15:0] rx_stop,
  output logic [7:0]  rx_lo_page,
  output logic [7:0]  rx_hi_page,
  output logic [7:0]  tx_lo_page,
  output logic [7:0]  tx_hi_page,
  output logic [47:0] station_addr
);
  localparam logic [3:0] A_CMD = 4'h0, A_STAT = 4'h1, A_ID = 4'h2, A_MASK = 4'h3;
  localparam logic [3:0] A_RXB = 4'h4, A_RXS = 4'h6, A_PTR = 4'hC, A_DATA = 4'hE;
  localparam logic [5:0] C_FULL_RST = 6'h0E;
  localparam logic [5:0] ID_LOW = 6'b100100;

  logic [3:0]  stat;
  logic [1:0]  id_cnt;
  logic [15:0] host_ptr;

  function automatic logic known_cmd(input logic [5:0] c);
    case (c)
      6'h03, 6'h04, 6'h07, 6'h08, 6'h0A, 6'h0B,
      6'h0E, 6'h18, 6'h1C, 6'h1E: known_cmd = 1'b1;
      default:                    known_cmd = 1'b0;
    endcase
  endfunction

  wire b0 = (bank_sel == 2'd0);
  wire b1 = (bank_sel == 2'd1);
  wire b2 = (bank_sel == 2'd2);
  wire wr_cmd   = host_wr && (host_addr == A_CMD);
  wire full_rst = wr_cmd && (host_wdata[5:0] == C_FULL_RST);
  wire sa_hit   = b2 && (host_addr >= 4'h4) && (host_addr <= 4'h9);
  wire [3:0] sa_idx = host_addr - 4'h4;
  wire dp_hit   = b0 && (host_addr == A_DATA);
  wire [3:0] evt_vec  = {evt_exec, evt_tx, evt_rx, evt_rx_stop};
  wire [3:0] stat_clr = (host_wr && b0 && host_addr == A_STAT) ? host_wdata[3:0] : 4'h0;

  assign buf_addr  = host_ptr;
  assign buf_wdata = host_wdata;
  assign buf_we    = host_wr && dp_hit;
  assign buf_re    = host_rd && dp_hit && !host_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_sel     <= 2'd0;
      cmd_stb      <= 1'b0;
      cmd_code     <= 6'd0;
      stat         <= 4'd0;
      int_mask     <= 4'd0;
      id_cnt       <= 2'd0;
      host_ptr     <= 16'd0;
      rx_base      <= 16'd0;
      rx_stop      <= 16'd0;
      rx_lo_page   <= 8'd0;
      rx_hi_page   <= 8'd0;
      tx_lo_page   <= 8'd0;
      tx_hi_page   <= 8'd0;
      station_addr <= 48'd0;
    end else begin
      cmd_stb <= 1'b0;
      if (wr_cmd) begin
        bank_sel <= host_wdata[7:6];
        if (known_cmd(host_wdata[5:0])) begin
          cmd_stb  <= 1'b1;
          cmd_code <= host_wdata[5:0];
        end
      end

      stat <= (stat & ~stat_clr) | evt_vec;

      if (host_rd && b0 && host_addr == A_ID)
        id_cnt <= id_cnt + 2'd1;

      if (host_wr && b0) begin
        case (host_addr)
          A_MASK:  int_mask <= host_wdata[3:0];
          A_RXB:   rx_base  <= host_wdata;
          A_RXS:   rx_stop  <= host_wdata;
          A_PTR:   host_ptr <= host_wdata;
          default: ;
        endcase
      end
      if ((host_wr || host_rd) && dp_hit)
        host_ptr <= host_ptr + 16'd2;

      if (host_wr && b1) begin
        case (host_addr)
          4'h8:    rx_lo_page <= host_wdata[7:0];
          4'h9:    rx_hi_page <= host_wdata[7:0];
          4'hA:    tx_lo_page <= host_wdata[7:0];
          4'hB:    tx_hi_page <= host_wdata[7:0];
          default: ;
        endcase
      end

      if (host_wr && sa_hit)
        station_addr[{sa_idx[2:0], 3'b000} +: 8] <= host_wdata[7:0];

      if (full_rst) begin
        bank_sel <= 2'd0;
        stat     <= 4'd0;
        int_mask <= 4'd0;
      end
    end
  end

  always_comb begin
    host_rdata = 16'h0000;
    if (host_addr == A_CMD) begin
      host_rdata = {8'h00, bank_sel, 6'b000000};
    end else if (b0) begin
      case (host_addr)
        A_STAT: host_rdata = {8'h00, 2'b00, exec_state, stat};
        A_ID:   host_rdata = {8'h00, id_cnt, ID_LOW};
        A_MASK: host_rdata = {12'h000, int_mask};
        A_RXB:  host_rdata = rx_base;
        A_RXS:  host_rdata = rx_stop;
        A_PTR:  host_rdata = host_ptr;
        A_DATA: host_rdata = buf_rdata;
        default: host_rdata = 16'h0000;
      endcase
    end else if (b1) begin
      case (host_addr)
        4'h8: host_rdata = {8'h00, rx_lo_page};
        4'h9: host_rdata = {8'h00, rx_hi_page};
        4'hA: host_rdata = {8'h00, tx_lo_page};
        4'hB: host_rdata = {8'h00, tx_hi_page};
        default: host_rdata = 16'h0000;
      endcase
    end else if (sa_hit) begin
      host_rdata = {8'h00, station_addr[{sa_idx[2:0], 3'b000} +: 8]};
    end
  end
endmodule

// File: rtl/bank_reg_if_chk.sv
module bank_reg_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic [15:0] buf_addr,
  input logic        cmd_stb,
  input logic [5:0]  cmd_code,
  input logic [1:0]  bank_sel,
  input logic [3:0]  int_mask,
  input logic [47:0] station_addr,
  input logic [3:0]  stat,
  input logic [1:0]  id_cnt
);
  p_cmd_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'h0 && host_wdata[5:0] == 6'h04 |=> cmd_stb && cmd_code == 6'h04);

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'h0 && host_wdata[5:0] == 6'h00 |=> !cmd_stb);

  p_full_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 4'h0 && host_wdata[5:0] == 6'h0E |=> bank_sel == 2'd0 && int_mask == 4'd0 && stat == 4'd0);

  p_id_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && bank_sel == 2'd0 && host_addr == 4'h2 |=> id_cnt == $past(id_cnt) + 2'd1);

  p_id_sig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && bank_sel == 2'd0 && host_addr == 4'h2 |-> (host_rdata[5:0] & 6'h2C) == 6'h24);

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && bank_sel == 2'd0 && host_addr == 4'hE |=> buf_addr == $past(buf_addr) + 16'd2);

  p_sa_byte0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && bank_sel == 2'd2 && host_addr == 4'h4 |=> station_addr[7:0] == $past(host_wdata[7:0]));

  p_bank3_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && bank_sel == 2'd3 && host_addr != 4'h0 |-> host_rdata == 16'h0000);
endmodule

bind bank_reg_if bank_reg_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .buf_addr(buf_addr), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
  .bank_sel(bank_sel), .int_mask(int_mask), .station_addr(station_addr),
  .stat(stat), .id_cnt(id_cnt)
);

// File: tb/bank_reg_if_tb.sv
module bank_reg_if_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0]  host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata, buf_addr, buf_wdata, buf_rdata;
  logic        buf_we, buf_re;
  logic        evt_rx_stop = 0, evt_rx = 0, evt_tx = 0, evt_exec = 0;
  logic [1:0]  exec_state = 0;
  logic        cmd_stb;
  logic [5:0]  cmd_code;
  logic [1:0]  bank_sel;
  logic [3:0]  int_mask;
  logic [15:0] rx_base, rx_stop;
  logic [7:0]  rx_lo_page, rx_hi_page, tx_lo_page, tx_hi_page;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  logic [15:0] mem [0:31];
  assign buf_rdata = mem[buf_addr[5:1]];

  bank_reg_if u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_re(buf_re),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .evt_rx_stop(evt_rx_stop), .evt_rx(evt_rx), .evt_tx(evt_tx),
    .evt_exec(evt_exec), .exec_state(exec_state), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .bank_sel(bank_sel), .int_mask(int_mask),
    .rx_base(rx_base), .rx_stop(rx_stop), .rx_lo_page(rx_lo_page),
    .rx_hi_page(rx_hi_page), .tx_lo_page(tx_lo_page), .tx_hi_page(tx_hi_page),
    .station_addr(station_addr)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [1:0]  m_bank;
  logic [3:0]  m_stat, m_mask;
  logic [1:0]  m_id;
  logic [15:0] m_rxb, m_rxs, m_ptr;
  logic [7:0]  m_lim [0:3];
  logic [7:0]  m_sa [0:5];
  logic [5:0]  m_code;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit known(input logic [5:0] c);
    return c inside {6'h03, 6'h04, 6'h07, 6'h08, 6'h0A, 6'h0B, 6'h0E, 6'h18, 6'h1C, 6'h1E};
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 0) return "R1";
    if (m_bank == 0) case (a)
      1: return "R5"; 2: return "R4"; 3: return "R6";
      4, 6, 12: return "R7"; 14: return "R8"; default: return "R11";
    endcase
    if (m_bank == 1) return (a >= 8 && a <= 11) ? "R9" : "R11";
    if (m_bank == 2) return (a >= 4 && a <= 9) ? "R10" : "R11";
    return "R11";
  endfunction

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    if (a == 0) return {8'h00, m_bank, 6'b0};
    if (m_bank == 0) case (a)
      1: return {10'h0, exec_state, m_stat};
      2: return {8'h00, m_id, 6'b100100};
      3: return {12'h0, m_mask};
      4: return m_rxb;
      6: return m_rxs;
      12: return m_ptr;
      14: return mem[m_ptr[5:1]];
      default: return 16'h0;
    endcase
    if (m_bank == 1 && a >= 8 && a <= 11) return {8'h00, m_lim[a-8]};
    if (m_bank == 2 && a >= 4 && a <= 9) return {8'h00, m_sa[a-4]};
    return 16'h0;
  endfunction

  task automatic model_reset();
    m_bank = 0; m_stat = 0; m_mask = 0; m_id = 0;
    m_rxb = 0; m_rxs = 0; m_ptr = 0; m_code = 0;
    for (int i = 0; i < 4; i++) m_lim[i] = 0;
    for (int i = 0; i < 6; i++) m_sa[i] = 0;
  endtask

  task automatic cmp_outputs();
    chk(bank_sel, m_bank, "R1 bank_sel");
    chk(int_mask, m_mask, "R6 int_mask");
    chk({rx_base, rx_stop}, {m_rxb, m_rxs}, "R7 rx_base/rx_stop");
    chk({rx_lo_page, rx_hi_page, tx_lo_page, tx_hi_page},
        {m_lim[0], m_lim[1], m_lim[2], m_lim[3]}, "R9 limit pages");
    chk(station_addr, {m_sa[5], m_sa[4], m_sa[3], m_sa[2], m_sa[1], m_sa[0]}, "R10 station_addr");
    chk(buf_addr, m_ptr, "R8 buf_addr");
  endtask

  task automatic cyc(input bit w, input bit r, input logic [3:0] a,
                     input logic [15:0] d, input logic [3:0] ev, input logic [1:0] xs);
    logic [1:0] ob;
    logic [3:0] clr;
    bit exp_stb;
    @(negedge clk);
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    {evt_exec, evt_tx, evt_rx, evt_rx_stop} = ev;
    exec_state = xs;
    #1;
    if (r) chk(host_rdata, exp_rd(a), tag_of(a));
    if (w && m_bank == 0 && a == 14) chk({buf_we, buf_wdata}, {1'b1, d}, "R8 write strobe");
    @(posedge clk);
    #1;
    ob = m_bank;
    clr = (w && ob == 0 && a == 1) ? d[3:0] : 4'h0;
    if (r && ob == 0 && a == 2) m_id = m_id + 1;
    if (w && ob == 0 && a == 14) mem[m_ptr[5:1]] = d;
    if ((w || r) && ob == 0 && a == 14) m_ptr = m_ptr + 2;
    if (w) begin
      if (a == 0) m_bank = d[7:6];
      if (ob == 0) case (a)
        3: m_mask = d[3:0]; 4: m_rxb = d; 6: m_rxs = d; 12: m_ptr = d;
        default: ;
      endcase
      if (ob == 1 && a >= 8 && a <= 11) m_lim[a-8] = d[7:0];
      if (ob == 2 && a >= 4 && a <= 9) m_sa[a-4] = d[7:0];
    end
    m_stat = (m_stat & ~clr) | ev;
    if (w && a == 0 && d[5:0] == 6'h0E) begin
      m_bank = 0; m_stat = 0; m_mask = 0;
    end
    exp_stb = w && a == 0 && known(d[5:0]);
    if (exp_stb) m_code = d[5:0];
    chk(cmd_stb, exp_stb, "R2 cmd_stb");
    if (exp_stb) chk(cmd_code, m_code, "R2 cmd_code");
    cmp_outputs();
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1, 0, a, d, 4'h0, exec_state);
  endtask
  task automatic rd(input logic [3:0] a);
    cyc(0, 1, a, 16'h0, 4'h0, exec_state);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R12: reset values
    chk({cmd_stb, bank_sel, int_mask}, 0, "R12 reset outputs");
    chk({rx_base, rx_stop, buf_addr}, 0, "R12 reset pointers");
    chk(station_addr, 0, "R12 reset station address");
    @(negedge clk); rst_n = 1;

    rd(4'h2); rd(4'h1);
    // R4: counter wraps after four reads
    for (int i = 0; i < 5; i++) rd(4'h2);
    // R2: codes not in the list give no strobe
    wr(4'h0, 16'h0005); wr(4'h0, 16'h003F); wr(4'h0, 16'h0004); wr(4'h0, 16'h001E);
    // R1: bank select through every bank
    wr(4'h0, 16'h0040); rd(4'h0); wr(4'h8, 16'h0011); wr(4'hB, 16'h00EE);
    wr(4'h0, 16'h0080); wr(4'h4, 16'h00A1); wr(4'h9, 16'h00F6); rd(4'h4); rd(4'h9);
    // R11: bank 3 and unused offsets
    wr(4'h0, 16'h00C0); wr(4'h8, 16'hFFFF); rd(4'h8); rd(4'h2);
    wr(4'h0, 16'h0000); wr(4'h5, 16'h1234); rd(4'h5); rd(4'hF);
    // R5: set beats clear in the same cycle, and exec state field
    cyc(0, 0, 4'h0, 16'h0, 4'hF, 2'd3); rd(4'h1);
    cyc(1, 0, 4'h1, 16'h0006, 4'h2, 2'd1); rd(4'h1);
    wr(4'h1, 16'h000F); rd(4'h1);
    // R8: data port write then read back after pointer reload
    wr(4'hC, 16'h0010);
    for (int i = 0; i < 4; i++) wr(4'hE, 16'hC000 + 16'(i));
    wr(4'hC, 16'h0010); rd(4'hC);
    for (int i = 0; i < 4; i++) rd(4'hE);
    wr(4'hC, 16'hFFFE); rd(4'hE); rd(4'hC);
    // R3: full reset while selecting bank 2 with pending events
    wr(4'h3, 16'h000B); cyc(0, 0, 4'h0, 16'h0, 4'h5, 2'd0);
    cyc(1, 0, 4'h0, 16'h008E, 4'hF, 2'd0); rd(4'h1); rd(4'h3);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op = 2'($urandom % 3);
      logic [3:0] ev = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      logic [15:0] d = 16'($urandom);
      logic [3:0] a = 4'($urandom);
      if (a == 0 && ($urandom % 4) != 0) a = 4'h2;
      cyc(op == 1, op == 2, a, d, ev, 2'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule